// File: doc/BRIEF.md
# CPU Interrupt Edge Detector and Poller

This block is the interrupt front end of an 8-bit CPU core. Once per CPU cycle, when the cycle strobe is high, it samples the active-low NMI line and the wired-OR of the active-low IRQ lines. NMI goes through a falling-edge detector that keeps a pending flag. IRQ is kept as a registered level. The sampled state becomes visible to the poll logic in the following cycle.

At every instruction boundary, marked by the sequencer's last-cycle indicator, the block chooses what the sequencer runs next: an NMI entry, an IRQ entry, or a normal opcode fetch. The choice uses the detector state as it stood after the instruction's second-to-last cycle. On the third cycle of a taken branch that does not cross a page, the choice uses the state from one cycle earlier, because no poll happens before that cycle. The request is registered and held until the next cycle strobe. Accepting an NMI produces a one-clock acknowledge and clears the pending edge.

Top module: `intr_poller`

## Requirements
- R1: While reset is held, and after its release, start_nmi, start_irq and nmi_ack are 0. Reset clears the previous NMI sample to "not asserted", so an nmi_n held low across reset release counts as one edge at the first cycle strobe.
- R2: Samples are taken, and start_nmi/start_irq change, only on clocks with cyc_en=1. An nmi_n pulse that is present only on clocks with cyc_en=0 has no effect.
- R3: A high-to-low transition of nmi_n, seen between two successive strobed samples, produces exactly one NMI entry. A line that stays low produces no further entry.
- R4: The decision at a strobe with last_cycle=1 uses the lines as sampled up to and including the preceding strobe. An NMI edge sampled in the second-to-last cycle is therefore taken at the end of the current instruction.
- R5: An NMI edge first sampled in the last cycle of an instruction is taken at the end of the next instruction.
- R6: When branch_t3=1 marks the last cycle, the decision uses the detector state as it stood after the instruction's first cycle. An edge sampled in the branch's second cycle is therefore deferred to the next instruction, while an edge sampled in its first cycle is taken.
- R7: If an NMI and an enabled IRQ are both pending at a boundary, the NMI wins. An IRQ that is still held is taken at the following boundary.
- R8: IRQ is taken only when i_flag=0 at the boundary. It is level-sensitive: it is taken again at every boundary while any irq_n bit stays low, and not taken once all bits are high.
- R9: The decision is registered at the strobe that ends the last cycle. Encoding: start_nmi=1 for NMI entry, start_irq=1 for IRQ entry, both 0 for an opcode fetch. The value holds until the next strobe, which returns both outputs to 0 unless it is itself a decision. The two outputs are never 1 together.
- R10: nmi_ack is a one-clock pulse that coincides with the rise of start_nmi and clears the pending NMI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_en | input | 1 | CPU cycle strobe; one high clock ends one CPU cycle |
| nmi_n | input | 1 | Non-maskable interrupt line, active low |
| irq_n | input | IRQ_SRC | Maskable interrupt sources, active low, wired-OR |
| i_flag | input | 1 | Interrupt-disable flag from the status register |
| last_cycle | input | 1 | Current CPU cycle is the last of the instruction |
| branch_t3 | input | 1 | Current cycle is the third cycle of a taken, non-page-crossing branch |
| start_nmi | output | 1 | Next sequence is an NMI entry |
| start_irq | output | 1 | Next sequence is an IRQ entry |
| nmi_ack | output | 1 | One-clock pulse when an NMI is accepted |

## Verification
The bound checker checks on every clock the following properties: the two start outputs are never high together, they hold between strobes, and any new request follows a strobed last cycle. It also checks that an IRQ start is only granted with the disable flag clear and that the NMI acknowledge is a single pulse aligned with the NMI start. Only the bench scenarios can show the cycle-exact poll point. These scenarios cover edges in the second-to-last and last cycles, the branch exception, edges seen across reset, single entry for a held NMI line, NMI-over-IRQ ordering and IRQ masking. Each one compares the entry chosen at every instruction boundary against an expected queue.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [1:0] {
    ENT_FETCH = 2'd0,
    ENT_NMI   = 2'd1,
    ENT_IRQ   = 2'd2
  } entry_e;
endpackage

// File: rtl/intr_rst_sync.sv
module intr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/intr_nmi_edge.sv
module intr_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic line_act,
  input  logic take,
  output logic pend
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic fall;

  always_comb begin
    fall   = line_act & ~prev_q;
    prev_d = prev_q;
    pend_d = pend_q;
    if (cyc_en) begin
      prev_d = line_act;
      // a fresh edge survives an acknowledge in the same cycle
      pend_d = fall | (pend_q & ~take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/intr_irq_level.sv
module intr_irq_level #(
  parameter int IRQ_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_en,
  input  logic [IRQ_SRC-1:0] irq_n,
  output logic               level
);
  logic [IRQ_SRC:0] any_act;
  logic             level_q, level_d;

  assign any_act[0] = 1'b0;
  for (genvar g = 0; g < IRQ_SRC; g++) begin : g_or
    assign any_act[g+1] = any_act[g] | ~irq_n[g];
  end

  always_comb begin
    level_d = level_q;
    if (cyc_en) level_d = any_act[IRQ_SRC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/intr_poll_hold.sv
module intr_poll_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic branch_t3,
  input  logic nmi_det,
  input  logic irq_det,
  output logic poll_nmi,
  output logic poll_irq
);
  logic snap_nmi_q, snap_nmi_d;
  logic snap_irq_q, snap_irq_d;

  always_comb begin
    snap_nmi_d = snap_nmi_q;
    snap_irq_d = snap_irq_q;
    if (cyc_en && !branch_t3) begin
      snap_nmi_d = nmi_det;
      snap_irq_d = irq_det;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_nmi_q <= 1'b0;
      snap_irq_q <= 1'b0;
    end else begin
      snap_nmi_q <= snap_nmi_d;
      snap_irq_q <= snap_irq_d;
    end
  end

  assign poll_nmi = branch_t3 ? snap_nmi_q : nmi_det;
  assign poll_irq = branch_t3 ? snap_irq_q : irq_det;
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic last_cycle,
  input  logic i_flag,
  input  logic poll_nmi,
  input  logic poll_irq,
  output logic take_nmi,
  output logic start_nmi,
  output logic start_irq,
  output logic nmi_ack
);
  entry_e entry_q, entry_d;
  logic   ack_q, ack_d;
  logic   take_irq;

  always_comb begin
    take_nmi = cyc_en & last_cycle & poll_nmi;
    take_irq = cyc_en & last_cycle & ~poll_nmi & poll_irq & ~i_flag;
    entry_d  = entry_q;
    if (cyc_en) begin
      if (take_nmi)      entry_d = ENT_NMI;
      else if (take_irq) entry_d = ENT_IRQ;
      else               entry_d = ENT_FETCH;
    end
    ack_d = take_nmi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= ENT_FETCH;
      ack_q   <= 1'b0;
    end else begin
      entry_q <= entry_d;
      ack_q   <= ack_d;
    end
  end

  assign start_nmi = (entry_q == ENT_NMI);
  assign start_irq = (entry_q == ENT_IRQ);
  assign nmi_ack   = ack_q;
endmodule

// File: rtl/intr_poller.sv
module intr_poller #(
  parameter int IRQ_SRC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_en,
  input  logic               nmi_n,
  input  logic [IRQ_SRC-1:0] irq_n,
  input  logic               i_flag,
  input  logic               last_cycle,
  input  logic               branch_t3,
  output logic               start_nmi,
  output logic               start_irq,
  output logic               nmi_ack
);
  logic rst_sync_n;
  logic nmi_pend, irq_lvl;
  logic poll_nmi, poll_irq;
  logic take_nmi;

  intr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  intr_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_sync_n), .cyc_en(cyc_en),
    .line_act(~nmi_n), .take(take_nmi), .pend(nmi_pend)
  );

  intr_irq_level #(.IRQ_SRC(IRQ_SRC)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .cyc_en(cyc_en),
    .irq_n(irq_n), .level(irq_lvl)
  );

  intr_poll_hold u_poll (
    .clk(clk), .rst_n(rst_sync_n), .cyc_en(cyc_en), .branch_t3(branch_t3),
    .nmi_det(nmi_pend), .irq_det(irq_lvl),
    .poll_nmi(poll_nmi), .poll_irq(poll_irq)
  );

  intr_arbiter u_arb (
    .clk(clk), .rst_n(rst_sync_n), .cyc_en(cyc_en), .last_cycle(last_cycle),
    .i_flag(i_flag), .poll_nmi(poll_nmi), .poll_irq(poll_irq),
    .take_nmi(take_nmi), .start_nmi(start_nmi), .start_irq(start_irq),
    .nmi_ack(nmi_ack)
  );
endmodule

// File: rtl/intr_poller_chk.sv
module intr_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_en,
  input logic i_flag,
  input logic last_cycle,
  input logic start_nmi,
  input logic start_irq,
  input logic nmi_ack
);
  assert_excl_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_nmi && start_irq));

  assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable({start_nmi, start_irq}));

  assert_start_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start_nmi) || $rose(start_irq)) |-> $past(cyc_en && last_cycle));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_irq) |-> $past(!i_flag));

  assert_ack_with_nmi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_nmi) |-> nmi_ack);

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> !nmi_ack);
endmodule

bind intr_poller intr_poller_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cyc_en(cyc_en), .i_flag(i_flag),
  .last_cycle(last_cycle), .start_nmi(start_nmi), .start_irq(start_irq),
  .nmi_ack(nmi_ack)
);

// File: tb/test_intr_poller.sv
`timescale 1ns/1ps
module test_intr_poller;
  import intr_pkg::*;

  localparam int IRQ_SRC = 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cyc_en;
  logic               nmi_n;
  logic [IRQ_SRC-1:0] irq_n;
  logic               i_flag;
  logic               last_cycle;
  logic               branch_t3;
  logic               start_nmi, start_irq, nmi_ack;

  int errors = 0;
  int checks = 0;

  typedef struct {
    entry_e exp;
    string  tag;
  } item_t;
  item_t exp_q[$];

  logic nmi_lvl = 1'b1;   // bench-side state of nmi_n
  logic last_seen = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  intr_poller #(.IRQ_SRC(IRQ_SRC)) i_intr_poller (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .nmi_n(nmi_n), .irq_n(irq_n),
    .i_flag(i_flag), .last_cycle(last_cycle), .branch_t3(branch_t3),
    .start_nmi(start_nmi), .start_irq(start_irq), .nmi_ack(nmi_ack)
  );

  task automatic check(string tag, logic [2:0] act, logic [2:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: {start_nmi,start_irq,nmi_ack} actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // one instruction of len cycles; nmi_n falls/rises at the given cycle (0 = no change)
  task automatic instr(int len, int fall_at, int rise_at, bit irq, bit ifl, bit bt3,
                       entry_e exp, string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    exp_q.push_back(it);
    for (int c = 1; c <= len; c++) begin
      @(negedge clk);
      if (c == fall_at) nmi_lvl = 1'b0;
      if (c == rise_at) nmi_lvl = 1'b1;
      nmi_n      = nmi_lvl;
      irq_n      = {~irq, 1'b1};
      i_flag     = ifl;
      cyc_en     = 1'b1;
      last_cycle = (c == len);
      branch_t3  = (c == len) && bt3;
    end
  endtask

  task automatic idle(logic nmi_v);
    @(negedge clk);
    cyc_en     = 1'b0;
    last_cycle = 1'b0;
    branch_t3  = 1'b0;
    nmi_n      = nmi_v;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: compare the boundary decision against the expected queue
  always @(posedge clk) last_seen <= cyc_en && last_cycle;

  always @(negedge clk) begin
    if (last_seen) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL queue: unexpected boundary, actual=%b expected=none",
                 {start_nmi, start_irq, nmi_ack});
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, {start_nmi, start_irq, nmi_ack},
              {it.exp == ENT_NMI, it.exp == ENT_IRQ, it.exp == ENT_NMI});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cyc_en = 1'b0; nmi_n = 1'b0; irq_n = '1;
    i_flag = 1'b0; last_cycle = 1'b0; branch_t3 = 1'b0;
    nmi_lvl = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {start_nmi, start_irq, nmi_ack}, 3'b000);
    rst_n = 1'b1;
    repeat (4) idle(1'b0);
    check("R1 after release", {start_nmi, start_irq, nmi_ack}, 3'b000);

    // R1: line held low across reset counts as one edge
    instr(2, 0, 0, 0, 0, 0, ENT_NMI,   "R1 held across reset");
    // R3: still low, no second entry
    instr(3, 0, 0, 0, 0, 0, ENT_FETCH, "R3 held low no repeat");
    instr(2, 0, 1, 0, 0, 0, ENT_FETCH, "R3 release");

    // R4: edge in second-to-last cycle is taken now
    instr(3, 2, 0, 0, 0, 0, ENT_NMI,   "R4 edge second-to-last");
    instr(2, 0, 1, 0, 0, 0, ENT_FETCH, "R4 after");

    // R5: edge in the last cycle waits one instruction
    instr(3, 3, 0, 0, 0, 0, ENT_FETCH, "R5 edge last cycle");
    instr(2, 0, 1, 0, 0, 0, ENT_NMI,   "R5 deferred");
    instr(2, 0, 0, 0, 0, 0, ENT_FETCH, "R5 after");

    // R6: taken branch third cycle
    instr(3, 2, 0, 0, 0, 1, ENT_FETCH, "R6 branch edge cycle2");
    instr(2, 0, 1, 0, 0, 0, ENT_NMI,   "R6 branch deferred");
    instr(3, 1, 0, 0, 0, 1, ENT_NMI,   "R6 branch edge cycle1");
    instr(2, 0, 1, 0, 0, 0, ENT_FETCH, "R6 after");

    // R8: level IRQ and mask
    instr(2, 0, 0, 1, 0, 0, ENT_IRQ,   "R8 irq enabled");
    instr(2, 0, 0, 1, 1, 0, ENT_FETCH, "R8 irq masked");
    instr(2, 0, 0, 1, 0, 0, ENT_IRQ,   "R8 irq still held");
    instr(2, 0, 0, 0, 0, 0, ENT_FETCH, "R8 irq released");

    // R7: NMI wins, held IRQ follows
    instr(3, 1, 0, 1, 0, 0, ENT_NMI,   "R7 nmi over irq");
    instr(2, 0, 1, 1, 0, 0, ENT_IRQ,   "R7 irq after nmi");
    instr(2, 0, 0, 0, 0, 0, ENT_FETCH, "R7 after");

    // R2: pulse only on non-strobe clocks is ignored
    idle(1'b0);
    idle(1'b0);
    idle(1'b1);
    instr(2, 0, 0, 0, 0, 0, ENT_FETCH, "R2 pulse between strobes");

    // R9: request holds across clocks without a strobe
    instr(2, 1, 0, 0, 0, 0, ENT_NMI,   "R9 nmi for hold");
    idle(1'b0);
    idle(1'b0);
    idle(1'b0);
    check("R9 hold without strobe", {start_nmi, start_irq, nmi_ack}, 3'b100);
    instr(2, 0, 1, 0, 0, 0, ENT_FETCH, "R9 cleared at next boundary");

    idle(1'b1);
    idle(1'b1);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL queue: actual=%0d left expected=0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule